// File: doc/BRIEF.md
# Link Packet Deframer

This block sits behind the byte capture stage of a point-to-point link. Every clock it takes one byte and a frame level. From these it rebuilds 104-bit mesh transactions. A transaction opens on a rising edge of the frame level. The first byte is a header, and it fixes how many bytes follow. The block gathers the address, data and return-address bytes, most significant byte first. It then writes the finished packet into one of two small buffers: one for writes and one for reads.

If the frame level stays high after the final byte of a transaction, the link keeps streaming. The sender skips the header and address bytes and starts the next transaction at its data bytes. The block reuses the previous header and steps the destination address forward by the size of one access.

Each buffer drives its own hold output back to the sender. The hold is raised early enough that one more complete transaction still fits after the sender sees it. Downstream logic drains each buffer with a ready input.

Top module: `lnk_deframer`

## Requirements
- R1: While rst_n is low, and after it is released with no traffic, wr_valid, rd_valid, wr_hold and rd_hold are all 0.
- R2: A header byte is taken only in a cycle where lnk_frame is 1 and was 0 in the previous cycle. The header bits are: bit0 access, bit1 write, bits 3:2 size code (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8), bits 7:4 control.
- R3: Bytes 1-4 carry the destination address and bytes 5-8 carry the data, each most significant byte first. Reads (write = 0) and writes with size code 3 also carry a return address in bytes 9-12, so their final byte is byte 12. Other writes end at byte 8 and report a return address of 0.
- R4: An output packet packs its fields as follows: bits 7:0 the header byte, bits 39:8 the destination, bits 71:40 the data, bits 103:72 the return address.
- R5: A packet with write = 1 goes to the wr_* side and one with write = 0 goes to the rd_* side. A packet whose access bit is 0 is discarded.
- R6: If lnk_frame is 1 in the cycle after a final byte, that byte is byte 5 of a new transaction. The new transaction keeps the header and uses destination = previous destination + 2^(size code).
- R7: If lnk_frame is 0 in the cycle after a final byte, the transaction ends. A later rising edge of lnk_frame starts a fresh transaction from byte 0.
- R8: If lnk_frame drops before the final byte, the partial transaction is discarded and produces no output.
- R9: The valid output of the target side rises on the first clock edge after the edge that captures the final byte, when that buffer was empty.
- R10: Hold rises on the second clock edge after the edge that captures the final byte of a packet that leaves its buffer holding DEPTH-1 packets. One more complete packet is still stored.
- R11: Each buffer is first-in first-out. The head is removed on a clock edge where valid and ready are both 1, and packets stay stored while ready is 0.
- R12: Hold falls on the clock edge after the buffer count drops below DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| lnk_frame | input | 1 | Frame level captured with each byte |
| lnk_byte | input | 8 | Captured link byte |
| wr_ready | input | 1 | Downstream accepts the write head |
| wr_valid | output | 1 | Write buffer holds a packet |
| wr_pkt | output | 104 | Write buffer head packet |
| wr_hold | output | 1 | Write pushback to the sender |
| rd_ready | input | 1 | Downstream accepts the read head |
| rd_valid | output | 1 | Read buffer holds a packet |
| rd_pkt | output | 104 | Read buffer head packet |
| rd_hold | output | 1 | Read pushback to the sender |

## Verification
The assertions assume the sender honours the hold outputs. No packet may finish into a buffer that is already full and not popping in the same cycle. They also assume that lnk_frame and lnk_byte settle away from the clock edge. The stimulus respects both. It changes inputs only at falling edges. During the hold test it sends exactly the one extra packet the hold allows, and drains the buffer before sending more.

// File: rtl/lnk_deframe_pkg.sv
package lnk_deframe_pkg;

  localparam int LNK_BYTE_W = 8;
  localparam int ADDR_W     = 32;
  localparam int IDX_W      = 4;

  // Packet as delivered: header byte at the bottom, return address on top.
  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] data;
    logic [ADDR_W-1:0] dst;
    logic [3:0]        ctrl;
    logic [1:0]        dmode;
    logic              write;
    logic              access;
  } mesh_pkt_t;

  localparam int PKT_W = $bits(mesh_pkt_t);

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_BODY = 2'd1,
    TRK_TAIL = 2'd2
  } trk_state_t;

  localparam logic [IDX_W-1:0] IDX_FIRST_BODY = 4'd1;
  localparam logic [IDX_W-1:0] IDX_DST_LAST   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_DATA_LAST  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_SHORT_END  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_LONG_END   = 4'd12;
  localparam logic [IDX_W-1:0] IDX_RESUME     = 4'd6;

  // Index of the final byte for a given header.
  function automatic logic [IDX_W-1:0] end_index(input logic write, input logic [1:0] dmode);
    end_index = (write && (dmode != 2'b11)) ? IDX_SHORT_END : IDX_LONG_END;
  endfunction

  // Address step between streamed transactions, in bytes.
  function automatic logic [ADDR_W-1:0] stride(input logic [1:0] dmode);
    stride = ADDR_W'(1) << dmode;
  endfunction

endpackage

// File: rtl/lnk_byte_tracker.sv
module lnk_byte_tracker
  import lnk_deframe_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_i,
  input  logic [LNK_BYTE_W-1:0] byte_i,
  output logic                  done_o,
  output mesh_pkt_t             pkt_o
);

  trk_state_t            st_q, st_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  frame_q;
  logic [LNK_BYTE_W-1:0] hdr_q, hdr_d;
  logic [ADDR_W-1:0]     dst_q, dst_d;
  logic [ADDR_W-1:0]     data_q, data_d;
  logic [ADDR_W-1:0]     src_q, src_d;
  logic                  done_q, done_d;

  logic rise, at_end, in_dst, in_data;

  assign rise    = frame_i & ~frame_q;
  assign at_end  = (idx_q == end_index(hdr_q[1], hdr_q[3:2]));
  assign in_dst  = (idx_q <= IDX_DST_LAST);
  assign in_data = (idx_q <= IDX_DATA_LAST);

  // Next-state process
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    hdr_d  = hdr_q;
    dst_d  = dst_q;
    data_d = data_q;
    src_d  = src_q;
    done_d = 1'b0;
    case (st_q)
      TRK_IDLE: begin
        if (rise) begin
          hdr_d = byte_i;
          src_d = '0;
          idx_d = IDX_FIRST_BODY;
          st_d  = TRK_BODY;
        end
      end
      TRK_BODY: begin
        if (!frame_i) begin
          st_d = TRK_IDLE;
        end else begin
          if (in_dst)       dst_d  = {dst_q[ADDR_W-LNK_BYTE_W-1:0], byte_i};
          else if (in_data) data_d = {data_q[ADDR_W-LNK_BYTE_W-1:0], byte_i};
          else              src_d  = {src_q[ADDR_W-LNK_BYTE_W-1:0], byte_i};
          if (at_end) begin
            st_d   = TRK_TAIL;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      TRK_TAIL: begin
        if (frame_i) begin
          // streaming: this byte is byte 5 of the next transaction
          dst_d  = dst_q + stride(hdr_q[3:2]);
          data_d = {data_q[ADDR_W-LNK_BYTE_W-1:0], byte_i};
          src_d  = '0;
          idx_d  = IDX_RESUME;
          st_d   = TRK_BODY;
        end else begin
          st_d = TRK_IDLE;
        end
      end
      default: st_d = TRK_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TRK_IDLE;
      idx_q   <= '0;
      frame_q <= 1'b0;
      hdr_q   <= '0;
      dst_q   <= '0;
      data_q  <= '0;
      src_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      frame_q <= frame_i;
      hdr_q   <= hdr_d;
      dst_q   <= dst_d;
      data_q  <= data_d;
      src_q   <= src_d;
      done_q  <= done_d;
    end
  end

  assign done_o       = done_q;
  assign pkt_o.src    = src_q;
  assign pkt_o.data   = data_q;
  assign pkt_o.dst    = dst_q;
  assign pkt_o.ctrl   = hdr_q[7:4];
  assign pkt_o.dmode  = hdr_q[3:2];
  assign pkt_o.write  = hdr_q[1];
  assign pkt_o.access = hdr_q[0];

  // R2: first body byte only follows a low-to-high frame change
  p_start_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_BODY && idx_q == IDX_FIRST_BODY) |-> ($past(frame_i) && !$past(frame_q)));

  // R9: completion is a single-cycle event
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: streamed transaction advances the destination by one access size
  p_stream_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_TAIL && frame_i) |=> (dst_q == $past(dst_q) + stride($past(hdr_q[3:2]))));

  // R8: frame loss mid-packet returns to idle without completing
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_BODY && !frame_i) |=> (st_q == TRK_IDLE && !done_q));

endmodule

// File: rtl/lnk_pkt_fifo.sv
module lnk_pkt_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 104
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic             hold_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HOLD_CNT = CNT_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             pop_ok, push_ok;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    ptr_step = (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  // Next-state process
  always_comb begin
    pop_ok   = pop_i && (cnt_q != '0);
    push_ok  = push_i && ((cnt_q != FULL_CNT) || pop_ok);
    wr_ptr_d = push_ok ? ptr_step(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok  ? ptr_step(rd_ptr_q) : rd_ptr_q;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
    hold_d = (cnt_q >= HOLD_CNT);
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      hold_q   <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      hold_q   <= hold_d;
    end
  end

  // Storage, written under an explicit enable, not reset
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_ptr_q];
  assign hold_o  = hold_q;

  // R10: the sender never completes a packet into a full, non-draining buffer
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && (cnt_q == FULL_CNT) && !pop_i));

  // R10: a full buffer has already raised its hold
  p_hold_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL_CNT) |-> hold_q);

endmodule

// File: rtl/lnk_deframer.sv
module lnk_deframer
  import lnk_deframe_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lnk_frame,
  input  logic [LNK_BYTE_W-1:0] lnk_byte,
  input  logic                  wr_ready,
  output logic                  wr_valid,
  output logic [PKT_W-1:0]      wr_pkt,
  output logic                  wr_hold,
  input  logic                  rd_ready,
  output logic                  rd_valid,
  output logic [PKT_W-1:0]      rd_pkt,
  output logic                  rd_hold
);

  localparam int N_CLASS = 2;  // index 0: reads, index 1: writes

  logic             done;
  mesh_pkt_t        pkt;
  logic [N_CLASS-1:0] push_v, pop_v, valid_v, hold_v;
  logic [PKT_W-1:0] head_v [N_CLASS];

  lnk_byte_tracker u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (lnk_frame),
    .byte_i  (lnk_byte),
    .done_o  (done),
    .pkt_o   (pkt)
  );

  assign pop_v = {wr_ready, rd_ready};

  for (genvar g = 0; g < N_CLASS; g++) begin : g_class
    assign push_v[g] = done & pkt.access & (pkt.write == 1'(g));
    lnk_pkt_fifo #(
      .DEPTH (DEPTH),
      .WIDTH (PKT_W)
    ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_v[g]),
      .data_i  (pkt),
      .pop_i   (pop_v[g]),
      .valid_o (valid_v[g]),
      .data_o  (head_v[g]),
      .hold_o  (hold_v[g])
    );
  end

  assign wr_valid = valid_v[1];
  assign wr_pkt   = head_v[1];
  assign wr_hold  = hold_v[1];
  assign rd_valid = valid_v[0];
  assign rd_pkt   = head_v[0];
  assign rd_hold  = hold_v[0];

endmodule

// File: tb/lnk_deframer_test.sv
module lnk_deframer_test;

  localparam int D = 4;

  logic         clk;
  logic         rst_n;
  logic         lnk_frame;
  logic [7:0]   lnk_byte;
  logic         wr_ready, rd_ready;
  logic         wr_valid, rd_valid, wr_hold, rd_hold;
  logic [103:0] wr_pkt, rd_pkt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  lnk_deframer #(.DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .lnk_frame(lnk_frame), .lnk_byte(lnk_byte),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_pkt(wr_pkt), .wr_hold(wr_hold),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_pkt(rd_pkt), .rd_hold(rd_hold)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input bit ok, input string req, input logic [103:0] act, input logic [103:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [103:0] mk(input logic [7:0] h, input logic [31:0] dst,
                                      input logic [31:0] dat, input logic [31:0] src);
    return {src, dat, dst, h};
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [103:0] wq[$], rq[$];
  int           m_st, m_idx;
  logic         m_fprev, m_pv, m_hw, m_hr;
  logic [7:0]   m_hdr;
  logic [31:0]  m_dst, m_dat, m_src;
  logic [103:0] m_pp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq.delete(); rq.delete();
      m_st = 0; m_idx = 0; m_fprev = 0; m_pv = 0; m_hw = 0; m_hr = 0;
      m_hdr = 0; m_dst = 0; m_dat = 0; m_src = 0; m_pp = 0;
    end else begin
      m_hw = (wq.size() >= D - 1);
      m_hr = (rq.size() >= D - 1);
      if (wr_ready && wq.size() > 0) void'(wq.pop_front());
      if (rd_ready && rq.size() > 0) void'(rq.pop_front());
      if (m_pv && m_pp[0]) begin
        if (m_pp[1]) begin if (wq.size() < D) wq.push_back(m_pp); end
        else         begin if (rq.size() < D) rq.push_back(m_pp); end
      end
      m_pv = 0;
      if (m_st == 0) begin
        if (lnk_frame && !m_fprev) begin m_hdr = lnk_byte; m_src = 0; m_idx = 1; m_st = 1; end
      end else if (m_st == 1) begin
        if (!lnk_frame) m_st = 0;
        else begin
          if (m_idx <= 4)      m_dst = {m_dst[23:0], lnk_byte};
          else if (m_idx <= 8) m_dat = {m_dat[23:0], lnk_byte};
          else                 m_src = {m_src[23:0], lnk_byte};
          if (m_idx == ((!m_hdr[1] || m_hdr[3:2] == 2'b11) ? 12 : 8)) begin
            m_pp = mk(m_hdr, m_dst, m_dat, m_src); m_pv = 1; m_st = 2;
          end else m_idx++;
        end
      end else begin
        if (lnk_frame) begin
          m_dst = m_dst + (32'd1 << m_hdr[3:2]);
          m_dat = {m_dat[23:0], lnk_byte}; m_src = 0; m_idx = 6; m_st = 1;
        end else m_st = 0;
      end
      m_fprev = lnk_frame;
    end
  end

  // Per-cycle comparison and delivery log
  logic [103:0] wlog[$], rlog[$];
  always @(negedge clk) begin
    if (rst_n) begin
      chk(wr_valid == (wq.size() != 0), "R9 wr_valid", 104'(wr_valid), 104'(wq.size() != 0));
      chk(rd_valid == (rq.size() != 0), "R9 rd_valid", 104'(rd_valid), 104'(rq.size() != 0));
      chk(wr_hold == m_hw, "R10 wr_hold", 104'(wr_hold), 104'(m_hw));
      chk(rd_hold == m_hr, "R10 rd_hold", 104'(rd_hold), 104'(m_hr));
      if (wr_valid && wq.size() != 0) chk(wr_pkt == wq[0], "R4 wr_pkt", wr_pkt, wq[0]);
      if (rd_valid && rq.size() != 0) chk(rd_pkt == rq[0], "R4 rd_pkt", rd_pkt, rq[0]);
      if (wr_valid && wr_ready) wlog.push_back(wr_pkt);
      if (rd_valid && rd_ready) rlog.push_back(rd_pkt);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(input logic fr, input logic [7:0] b);
    lnk_frame = fr; lnk_byte = b;
    @(negedge clk);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00);
  endtask

  task automatic send_body(input logic [7:0] h, input logic [31:0] dat, input logic [31:0] src);
    for (int i = 3; i >= 0; i--) drive(1'b1, dat[i*8 +: 8]);
    if (!h[1] || h[3:2] == 2'b11)
      for (int i = 3; i >= 0; i--) drive(1'b1, src[i*8 +: 8]);
  endtask

  task automatic send_pkt(input logic [7:0] h, input logic [31:0] dst,
                          input logic [31:0] dat, input logic [31:0] src);
    drive(1'b1, h);
    for (int i = 3; i >= 0; i--) drive(1'b1, dst[i*8 +: 8]);
    send_body(h, dat, src);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    rst_n = 1'b0; lnk_frame = 1'b0; lnk_byte = 8'h00; wr_ready = 1'b1; rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({wr_valid, rd_valid, wr_hold, rd_hold} == 4'b0, "R1 in reset",
        104'({wr_valid, rd_valid, wr_hold, rd_hold}), 104'(0));
    rst_n = 1'b1;
    gap(2);
    chk({wr_valid, rd_valid, wr_hold, rd_hold} == 4'b0, "R1 after release",
        104'({wr_valid, rd_valid, wr_hold, rd_hold}), 104'(0));

    // R2 R3 R9: 4-byte write, frame low after the final byte
    send_pkt(8'h5B, 32'h1000_0000, 32'hDEAD_BEEF, 32'h0);
    chk(wr_valid == 1'b0, "R9 not yet valid", 104'(wr_valid), 104'(0));
    drive(1'b0, 8'h00);
    chk(wr_valid == 1'b1, "R9 valid one edge later", 104'(wr_valid), 104'(1));
    gap(3);
    chk(wlog.size() == 1, "R2 one write delivered", 104'(wlog.size()), 104'(1));
    chk(wlog[0] == mk(8'h5B, 32'h1000_0000, 32'hDEAD_BEEF, 32'h0), "R3 short write fields",
        wlog[0], mk(8'h5B, 32'h1000_0000, 32'hDEAD_BEEF, 32'h0));

    // R5: read goes to the read side with a return address
    send_pkt(8'h09, 32'h2000_0010, 32'h0000_0000, 32'h8000_0040);
    gap(4);
    chk(rlog.size() == 1 && rlog[0] == mk(8'h09, 32'h2000_0010, 32'h0, 32'h8000_0040),
        "R5 read routed", rlog[0], mk(8'h09, 32'h2000_0010, 32'h0, 32'h8000_0040));

    // R5: access bit clear -> discarded
    send_pkt(8'h0A, 32'h3000_0000, 32'h1234_5678, 32'h0);
    gap(4);
    chk(wlog.size() == 1 && rlog.size() == 1, "R5 access clear dropped",
        104'(wlog.size() + rlog.size()), 104'(2));

    // R6: streamed 2-byte writes
    send_pkt(8'h37, 32'h0000_0100, 32'h1111_2222, 32'h0);
    send_body(8'h37, 32'h3333_4444, 32'h0);
    send_body(8'h37, 32'h5555_6666, 32'h0);
    gap(4);
    chk(wlog.size() == 4, "R6 three streamed writes", 104'(wlog.size()), 104'(4));
    chk(wlog[2] == mk(8'h37, 32'h0000_0102, 32'h3333_4444, 32'h0), "R6 second stream step",
        wlog[2], mk(8'h37, 32'h0000_0102, 32'h3333_4444, 32'h0));
    chk(wlog[3] == mk(8'h37, 32'h0000_0104, 32'h5555_6666, 32'h0), "R6 third stream step",
        wlog[3], mk(8'h37, 32'h0000_0104, 32'h5555_6666, 32'h0));

    // R6 R3: streamed 8-byte reads carry return addresses
    send_pkt(8'h0D, 32'h0000_4000, 32'h0000_0001, 32'h0000_00A0);
    send_body(8'h0D, 32'h0000_0002, 32'h0000_00B0);
    gap(4);
    chk(rlog.size() == 3 && rlog[2] == mk(8'h0D, 32'h0000_4008, 32'h2, 32'hB0),
        "R6 streamed read", rlog[2], mk(8'h0D, 32'h0000_4008, 32'h2, 32'hB0));

    // R3: 8-byte write has 13 bytes
    send_pkt(8'h0F, 32'h0000_0050, 32'h0000_0077, 32'h0000_0099);
    gap(4);
    chk(wlog.size() == 5 && wlog[4] == mk(8'h0F, 32'h50, 32'h77, 32'h99), "R3 long write",
        wlog[4], mk(8'h0F, 32'h50, 32'h77, 32'h99));

    // R8: abort mid-packet, then a clean packet
    drive(1'b1, 8'h5B); drive(1'b1, 8'hAA); drive(1'b1, 8'hBB); drive(1'b1, 8'hCC);
    drive(1'b0, 8'h00);
    send_pkt(8'h1B, 32'h0000_0060, 32'h0000_CAFE, 32'h0);
    gap(4);
    chk(wlog.size() == 6 && wlog[5] == mk(8'h1B, 32'h60, 32'hCAFE, 32'h0), "R8 partial discarded",
        wlog[5], mk(8'h1B, 32'h60, 32'hCAFE, 32'h0));

    // R7: one low cycle then a fresh header
    send_pkt(8'h5B, 32'h0000_0070, 32'h0000_0001, 32'h0);
    drive(1'b0, 8'h00);
    send_pkt(8'h5B, 32'h0000_0080, 32'h0000_0002, 32'h0);
    gap(4);
    chk(wlog.size() == 8 && wlog[7] == mk(8'h5B, 32'h80, 32'h2, 32'h0), "R7 fresh header",
        wlog[7], mk(8'h5B, 32'h80, 32'h2, 32'h0));

    // R10 R11 R12: hold timing with the write side stalled
    wr_ready = 1'b0;
    send_pkt(8'h5B, 32'h90, 32'd10, 32'h0); gap(3);
    send_pkt(8'h5B, 32'h94, 32'd11, 32'h0); gap(3);
    chk(wr_hold == 1'b0, "R10 two stored no hold", 104'(wr_hold), 104'(0));
    send_pkt(8'h5B, 32'h98, 32'd12, 32'h0);
    drive(1'b0, 8'h00);
    chk(wr_hold == 1'b0, "R10 hold not after first edge", 104'(wr_hold), 104'(0));
    drive(1'b0, 8'h00);
    chk(wr_hold == 1'b1, "R10 hold after second edge", 104'(wr_hold), 104'(1));
    send_pkt(8'h5B, 32'h9C, 32'd13, 32'h0); gap(3);
    chk(wlog.size() == 8, "R11 nothing removed while stalled", 104'(wlog.size()), 104'(8));
    wr_ready = 1'b1;
    gap(8);
    chk(wr_hold == 1'b0, "R12 hold released", 104'(wr_hold), 104'(0));
    chk(wlog.size() == 12, "R10 extra packet kept", 104'(wlog.size()), 104'(12));
    for (int i = 0; i < 4; i++)
      chk(wlog.size() == 12 && wlog[8 + i][71:40] == 32'(10 + i), "R11 order",
          104'(wlog[8 + i][71:40]), 104'(10 + i));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule